// File: doc/BRIEF.md
# CompactFlash Card Access Controller

This block lets an internal bus master read and write a CompactFlash card in memory mode, reaching either common memory or attribute/configuration space. The master raises a request carrying an address, write data, a direction, a byte-or-word size and an attribute flag. It holds the request until a one-cycle acknowledge returns. The acknowledge carries read data and an error flag.

On the card side the controller drives an 11-bit address and two active-low byte-lane enables. It also drives the common/attribute select, a read strobe, a write strobe and the write data with its drive enable. Every access passes through three phases: address setup, strobe, hold. The strobe lasts at least a programmable number of cycles and is stretched for as long as the card pulls its wait line low.

The controller also watches the two card-detect pins and debounces them. While no card is present it holds the card in reset, and a card removal aborts any access in flight. It drives the 3.3 V supply enable from the voltage-sense pin. It reports the ready/interrupt pin both as a ready level and as an interrupt request.

Top module: `cfc_ctrl`

## Requirements
- R1: `card_present` rises only after both detect inputs, seen through a two-flop synchronizer, have read low for DEB_CYC consecutive cycles. It falls only after DEB_CYC consecutive cycles in which they do not both read low.
- R2: `card_reset` is high whenever `card_present` is low, and it is high after reset.
- R3: `card_vcc3_en_n` is low only when the synchronized voltage-sense input reads 0, two cycles after the pin changes. It is high in every other case.
- R4: For a word access (`req_word`=1) both lane enables are low and `card_addr[0]` is 0. For a byte access `card_ce1_n` is low, `card_ce2_n` is high and `card_addr[0]` follows `req_addr[0]`. Byte reads return D7..D0 in `req_rdata[7:0]` with the upper byte 0. Both enables are high when idle.
- R5: During an access `card_reg_n` is low for an attribute access (`req_attr`=1) and high for common memory. It is high when idle.
- R6: An accepted request shows the address with enables for SETUP_CYC cycles first. The strobe (`card_oe_n` for reads, `card_we_n` for writes) then stays low for max(`cfg_strobe_min`,1) cycles. The address is held for HOLD_CYC more cycles, and `req_ack` pulses in the cycle after the hold ends.
- R7: The strobe does not end while the synchronized `card_wait_n` is low, so the strobe phase grows by the length of the wait.
- R8: On a write, `card_d_oe` is high and `card_d_out` carries the write data for the whole access, so the card sees the data stable at the strobe's rising edge. On a read, the data is captured in the last strobe cycle and returned with the acknowledge.
- R9: A request while no card is present is acknowledged with `req_err`=1 and no strobe. A card loss during an access ends it at once with `req_ack`, `req_err`=1 and both strobes high.
- R10: `card_ready` follows the synchronized ready input. `card_irq` is high when a card is present and the synchronized ready input is low.
- R11: At most one strobe is low at a time, and `req_ack` is never high in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_strobe_min | input | STRB_W | Minimum strobe length in cycles (0 acts as 1) |
| req_valid | input | 1 | Request held until acknowledge |
| req_write | input | 1 | 1 write, 0 read |
| req_attr | input | 1 | 1 attribute space, 0 common memory |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 11 | Card address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Completion without a card |
| req_rdata | output | 16 | Read data, valid with acknowledge |
| card_addr | output | 11 | Card address bus |
| card_ce1_n | output | 1 | Low-lane enable, active low |
| card_ce2_n | output | 1 | High-lane enable, active low |
| card_reg_n | output | 1 | High common, low attribute |
| card_oe_n | output | 1 | Read strobe, active low |
| card_we_n | output | 1 | Write strobe, active low |
| card_d_out | output | 16 | Write data to card |
| card_d_oe | output | 1 | Data bus drive enable |
| card_d_in | input | 16 | Data from card |
| card_wait_n | input | 1 | Low extends the cycle |
| card_rdy | input | 1 | Ready (memory) / interrupt low (I/O) |
| card_cd1_n | input | 1 | Card detect 1, active low |
| card_cd2_n | input | 1 | Card detect 2, active low |
| card_vs1_n | input | 1 | Voltage sense |
| card_vcc3_en_n | output | 1 | 3.3 V supply enable, active low |
| card_reset | output | 1 | Card reset, active high |
| card_present | output | 1 | Debounced card presence |
| card_ready | output | 1 | Synchronized ready level |
| card_irq | output | 1 | Interrupt request from the card |

## Verification
The bench builds the controller with SETUP_CYC=2, HOLD_CYC=1, DEB_CYC=5 and a 4-bit strobe length. The short debounce makes insertion, removal and removal in mid-access reachable within a few dozen cycles. The 4-bit length field lets a zero setting and a wait-stretched strobe be compared against the programmed minimum. A two-cycle setup keeps the setup phase distinct from the strobe phase in the cycle-by-cycle comparison.

// File: rtl/cfc_pkg.sv
// Shared widths, phase encoding and latched request type for the
// card access controller. Assumes a 16-bit card data path.
package cfc_pkg;
    localparam int CFC_ADDR_W = 11;
    localparam int CFC_DATA_W = 16;
    localparam int CFC_LANE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } cfc_phase_e;

    typedef struct packed {
        logic                  wr;
        logic                  attr;
        logic                  word;
        logic [CFC_ADDR_W-1:0] addr;
        logic [CFC_DATA_W-1:0] wdata;
    } cfc_req_t;
endpackage

// File: rtl/cfc_sync.sv
// Two-flop synchronizer for a vector of asynchronous card pins.
// Assumes each bit is independent; RST_VAL gives the idle level.
module cfc_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the raw pins through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cfc_detect.sv
// Debounces the synchronized "both detect pins low" level into a
// presence flag. Assumes DEB_CYC >= 2; both directions use the same filter.
module cfc_detect #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic both_low,
    output logic present
);
    localparam int CW = $clog2(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive disagreeing samples; flip after DEB_CYC of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present <= 1'b0;
            run_cnt <= '0;
        end else if (both_low != present) begin
            if (run_cnt == LAST) begin
                present <= both_low;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // R1: presence only ever moves to the level sampled before the edge.
    a_r1_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(present) |-> (present == $past(both_low)));
endmodule

// File: rtl/cfc_lanes.sv
// Maps the access size and address bit 0 to the two lane enables and
// the driven address bit. Purely combinational; idle drives both high.
module cfc_lanes (
    input  logic active,
    input  logic word,
    input  logic a0,
    output logic ce1_n,
    output logic ce2_n,
    output logic lane_a0
);
    // Word: both lanes, bit 0 forced low. Byte: low lane, bit 0 picks byte.
    always_comb begin
        ce1_n   = !active;
        ce2_n   = !(active && word);
        lane_a0 = active && !word && a0;
    end
endmodule

// File: rtl/cfc_seq.sv
// Access sequencer: setup, strobe (minimum length, stretched by wait),
// hold, then a one-cycle acknowledge. Aborts with an error if the card
// disappears. Assumes SETUP_CYC >= 1 and HOLD_CYC >= 1.
module cfc_seq
    import cfc_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int STRB_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  present,
    input  logic                  wait_ok,
    input  logic [STRB_W-1:0]     strobe_min,
    input  logic                  req_valid,
    input  cfc_req_t              req_in,
    input  logic [CFC_DATA_W-1:0] bus_in,
    output cfc_phase_e            phase,
    output cfc_req_t              held,
    output logic                  ack_o,
    output logic                  err_o,
    output logic [CFC_DATA_W-1:0] rdata_o
);
    localparam int SW  = $clog2(SETUP_CYC + 1);
    localparam int HW  = $clog2(HOLD_CYC + 1);
    localparam int CW0 = (SW > HW) ? SW : HW;
    localparam int CW  = (CW0 > STRB_W) ? CW0 : STRB_W;
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

    logic [CW-1:0]         cnt;
    logic [STRB_W-1:0]     min_eff;
    logic [CW-1:0]         strobe_last;
    logic [CFC_DATA_W-1:0] read_word;

    // Effective strobe length: zero is treated as one cycle.
    always_comb begin
        min_eff     = (strobe_min == '0) ? STRB_W'(1) : strobe_min;
        strobe_last = CW'(min_eff) - 1'b1;
        read_word   = held.word ? bus_in
                                : {{(CFC_DATA_W-CFC_LANE_W){1'b0}}, bus_in[CFC_LANE_W-1:0]};
    end

    // Phase machine with per-phase counter, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            held    <= '0;
            cnt     <= '0;
            ack_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o <= 1'b0;
            err_o <= 1'b0;
            if (phase != PH_IDLE && !present) begin
                phase   <= PH_IDLE;
                ack_o   <= 1'b1;
                err_o   <= 1'b1;
                rdata_o <= '0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (req_valid && !ack_o) begin
                            rdata_o <= '0;
                            if (!present) begin
                                ack_o <= 1'b1;
                                err_o <= 1'b1;
                            end else begin
                                held  <= req_in;
                                phase <= PH_SETUP;
                                cnt   <= '0;
                            end
                        end
                    end
                    PH_SETUP: begin
                        if (cnt == SETUP_LAST) begin
                            phase <= PH_STROBE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_STROBE: begin
                        if (cnt >= strobe_last && wait_ok) begin
                            phase <= PH_HOLD;
                            cnt   <= '0;
                            if (!held.wr) rdata_o <= read_word;
                        end else if (cnt < strobe_last) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == HOLD_LAST) begin
                            phase <= PH_IDLE;
                            ack_o <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R7: a held-off wait keeps the strobe phase.
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE && !wait_ok && present) |=> (phase == PH_STROBE));
    // R9: card loss mid-access returns to idle with an error acknowledge.
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !present) |=> (phase == PH_IDLE && ack_o && err_o));
    // R11: acknowledge is a single-cycle pulse.
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R6: an access always starts with the setup phase.
    a_r6_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_SETUP));
endmodule

// File: rtl/cfc_ctrl.sv
// CompactFlash memory-mode access controller top. Synchronizes the card
// pins, qualifies presence, sequences accesses and drives the card bus.
// Assumes card pins are asynchronous and the master holds req until ack.
module cfc_ctrl
    import cfc_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int DEB_CYC   = 16,
    parameter int STRB_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRB_W-1:0]     cfg_strobe_min,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_attr,
    input  logic                  req_word,
    input  logic [CFC_ADDR_W-1:0] req_addr,
    input  logic [CFC_DATA_W-1:0] req_wdata,
    output logic                  req_ack,
    output logic                  req_err,
    output logic [CFC_DATA_W-1:0] req_rdata,
    output logic [CFC_ADDR_W-1:0] card_addr,
    output logic                  card_ce1_n,
    output logic                  card_ce2_n,
    output logic                  card_reg_n,
    output logic                  card_oe_n,
    output logic                  card_we_n,
    output logic [CFC_DATA_W-1:0] card_d_out,
    output logic                  card_d_oe,
    input  logic [CFC_DATA_W-1:0] card_d_in,
    input  logic                  card_wait_n,
    input  logic                  card_rdy,
    input  logic                  card_cd1_n,
    input  logic                  card_cd2_n,
    input  logic                  card_vs1_n,
    output logic                  card_vcc3_en_n,
    output logic                  card_reset,
    output logic                  card_present,
    output logic                  card_ready,
    output logic                  card_irq
);
    localparam int NPIN = 5;

    logic [NPIN-1:0] pins_s;
    logic            cd1_s, cd2_s, vs_s, wait_s, rdy_s;
    logic            present;
    cfc_req_t        req_in, held;
    cfc_phase_e      phase;
    logic            active, lane_a0;

    cfc_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({card_cd1_n, card_cd2_n, card_vs1_n, card_wait_n, card_rdy}),
        .q (pins_s)
    );

    // Unpack the synchronized pins.
    always_comb begin
        {cd1_s, cd2_s, vs_s, wait_s, rdy_s} = pins_s;
    end

    cfc_detect #(.DEB_CYC(DEB_CYC)) u_detect (
        .clk (clk),
        .rst_n (rst_n),
        .both_low (!cd1_s && !cd2_s),
        .present (present)
    );

    // Pack the master's request fields.
    always_comb begin
        req_in.wr    = req_write;
        req_in.attr  = req_attr;
        req_in.word  = req_word;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
    end

    cfc_seq #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .STRB_W(STRB_W)) u_seq (
        .clk (clk),
        .rst_n (rst_n),
        .present (present),
        .wait_ok (wait_s),
        .strobe_min (cfg_strobe_min),
        .req_valid (req_valid),
        .req_in (req_in),
        .bus_in (card_d_in),
        .phase (phase),
        .held (held),
        .ack_o (req_ack),
        .err_o (req_err),
        .rdata_o (req_rdata)
    );

    assign active = (phase != PH_IDLE);

    cfc_lanes u_lanes (
        .active (active),
        .word (held.word),
        .a0 (held.addr[0]),
        .ce1_n (card_ce1_n),
        .ce2_n (card_ce2_n),
        .lane_a0 (lane_a0)
    );

    // Card bus, strobes and status outputs from registered state.
    always_comb begin
        card_addr      = active ? {held.addr[CFC_ADDR_W-1:1], lane_a0} : '0;
        card_reg_n     = !(active && held.attr);
        card_oe_n      = !(phase == PH_STROBE && !held.wr);
        card_we_n      = !(phase == PH_STROBE && held.wr);
        card_d_out     = held.wdata;
        card_d_oe      = active && held.wr;
        card_vcc3_en_n = vs_s;
        card_reset     = !present;
        card_present   = present;
        card_ready     = rdy_s;
        card_irq       = present && !rdy_s;
    end

    // R11: never both strobes at once.
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!card_oe_n, !card_we_n}));
    // R4: the high lane is only ever enabled together with the low lane.
    a_r4_lane_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !card_ce2_n |-> !card_ce1_n);
    // R8: a write strobe always has the data driven.
    a_r8_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !card_we_n |-> card_d_oe);
    // R9: once absence is settled, no strobe reaches the card.
    a_r9_no_strobe_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_present && $past(!card_present)) |-> (card_oe_n && card_we_n));
endmodule

// File: tb/cfc_ctrl_bench.sv
module cfc_ctrl_bench;
    localparam int SETUP = 2;
    localparam int HOLD  = 1;
    localparam int DEB   = 5;
    localparam int SW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] cfg_strobe_min = 4'd3;
    logic req_valid = 0, req_write = 0, req_attr = 0, req_word = 0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ack, req_err;
    logic [15:0] req_rdata;
    logic [10:0] card_addr;
    logic card_ce1_n, card_ce2_n, card_reg_n, card_oe_n, card_we_n, card_d_oe;
    logic [15:0] card_d_out;
    logic [15:0] card_d_in = 16'hA55A;
    logic card_wait_n = 1, card_rdy = 1, card_cd1_n = 1, card_cd2_n = 1, card_vs1_n = 1;
    logic card_vcc3_en_n, card_reset, card_present, card_ready, card_irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    cfc_ctrl #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .DEB_CYC(DEB), .STRB_W(SW)) u_cfc_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_strobe_min(cfg_strobe_min),
        .req_valid(req_valid), .req_write(req_write), .req_attr(req_attr),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .card_addr(card_addr), .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n),
        .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
        .card_d_out(card_d_out), .card_d_oe(card_d_oe), .card_d_in(card_d_in),
        .card_wait_n(card_wait_n), .card_rdy(card_rdy), .card_cd1_n(card_cd1_n),
        .card_cd2_n(card_cd2_n), .card_vs1_n(card_vs1_n),
        .card_vcc3_en_n(card_vcc3_en_n), .card_reset(card_reset),
        .card_present(card_present), .card_ready(card_ready), .card_irq(card_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit sy_both[2], sy_vs[2], sy_wt[2], sy_rd[2];
    int m_pres, m_deb, m_ph, m_cnt, m_ack, m_err, m_rdata;
    int m_wr, m_attr, m_word, m_addr, m_wdata;

    always @(posedge clk) begin
        int p, wt, minv, na, ne;
        if (!rst_n) begin
            sy_both = '{0, 0}; sy_vs = '{1, 1}; sy_wt = '{1, 1}; sy_rd = '{1, 1};
            m_pres = 0; m_deb = 0; m_ph = 0; m_cnt = 0; m_ack = 0; m_err = 0; m_rdata = 0;
            m_wr = 0; m_attr = 0; m_word = 0; m_addr = 0; m_wdata = 0;
        end else begin
            p = m_pres; wt = sy_wt[1];
            minv = (cfg_strobe_min == 0) ? 1 : int'(cfg_strobe_min);
            na = 0; ne = 0;
            if (int'(sy_both[1]) != m_pres) begin
                if (m_deb == DEB - 1) begin m_pres = sy_both[1]; m_deb = 0; end
                else m_deb++;
            end else m_deb = 0;
            if (m_ph != 0 && !p) begin
                m_ph = 0; na = 1; ne = 1; m_rdata = 0;
            end else if (m_ph == 0) begin
                if (req_valid && !m_ack) begin
                    m_rdata = 0;
                    if (!p) begin na = 1; ne = 1; end
                    else begin
                        m_wr = req_write; m_attr = req_attr; m_word = req_word;
                        m_addr = req_addr; m_wdata = req_wdata; m_ph = 1; m_cnt = 0;
                    end
                end
            end else if (m_ph == 1) begin
                if (m_cnt == SETUP - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 2) begin
                if (m_cnt >= minv - 1 && wt) begin
                    m_ph = 3; m_cnt = 0;
                    if (!m_wr) m_rdata = m_word ? int'(card_d_in) : int'(card_d_in[7:0]);
                end else if (m_cnt < minv - 1) m_cnt++;
            end else begin
                if (m_cnt == HOLD - 1) begin m_ph = 0; na = 1; end else m_cnt++;
            end
            m_ack = na; m_err = ne;
            sy_both[1] = sy_both[0]; sy_both[0] = !card_cd1_n && !card_cd2_n;
            sy_vs[1] = sy_vs[0]; sy_vs[0] = card_vs1_n;
            sy_wt[1] = sy_wt[0]; sy_wt[0] = card_wait_n;
            sy_rd[1] = sy_rd[0]; sy_rd[0] = card_rdy;
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        int act, e_a0, e_addr;
        if (rst_n) begin
            act = (m_ph != 0);
            e_a0 = act && !m_word && m_addr[0];
            e_addr = act ? ((m_addr & 11'h7FE) | e_a0) : 0;
            check(card_oe_n == !(m_ph == 2 && !m_wr), "R6 oe_n", card_oe_n, !(m_ph == 2 && !m_wr));
            check(card_we_n == !(m_ph == 2 && m_wr), "R7 we_n", card_we_n, !(m_ph == 2 && m_wr));
            check(card_ce1_n == !act, "R4 ce1_n", card_ce1_n, !act);
            check(card_ce2_n == !(act && m_word), "R4 ce2_n", card_ce2_n, !(act && m_word));
            check(int'(card_addr) == e_addr, "R4 addr", card_addr, e_addr);
            check(card_reg_n == !(act && m_attr), "R5 reg_n", card_reg_n, !(act && m_attr));
            check(card_d_oe == (act && m_wr), "R8 d_oe", card_d_oe, act && m_wr);
            check(req_ack == m_ack, "R11 ack", req_ack, m_ack);
            check(req_err == m_err, "R9 err", req_err, m_err);
            if (m_ack) check(int'(req_rdata) == m_rdata, "R8 rdata", req_rdata, m_rdata);
            check(card_present == m_pres, "R1 present", card_present, m_pres);
            check(card_reset == !m_pres, "R2 reset", card_reset, !m_pres);
            check(card_vcc3_en_n == sy_vs[1], "R3 vcc3", card_vcc3_en_n, sy_vs[1]);
            check(card_ready == sy_rd[1], "R10 ready", card_ready, sy_rd[1]);
            check(card_irq == (m_pres && !sy_rd[1]), "R10 irq", card_irq, m_pres && !sy_rd[1]);
        end
    end

    // ---------------- directed stimulus ----------------
    int n_strobe;
    logic cap_ce1, cap_ce2, cap_a0, cap_reg, cap_doe;
    logic [15:0] cap_dout, got_rdata;
    logic got_err;

    task automatic access(input bit wr, input bit attr, input bit word,
                          input logic [10:0] a, input logic [15:0] wd);
        int n = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_attr = attr; req_word = word;
        req_addr = a; req_wdata = wd; n_strobe = 0;
        do begin
            @(negedge clk); n++;
            if (!card_oe_n || !card_we_n) begin
                n_strobe++;
                cap_ce1 = card_ce1_n; cap_ce2 = card_ce2_n; cap_a0 = card_addr[0];
                cap_reg = card_reg_n; cap_doe = card_d_oe; cap_dout = card_d_out;
            end
        end while (!req_ack && n < 300);
        got_rdata = req_rdata; got_err = req_err;
        req_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check(card_reset == 1 && card_present == 0, "R2 reset state", card_reset, 1);
        check(card_oe_n && card_we_n && card_ce1_n && !req_ack, "R6 idle after reset", card_oe_n, 1);
        rst_n = 1;
        // R9 request with no card
        access(0, 0, 1, 11'h010, 16'h0);
        check(got_err == 1 && n_strobe == 0, "R9 absent request", n_strobe, 0);
        // R1 insertion
        card_cd1_n = 0; card_cd2_n = 0;
        repeat (DEB) @(negedge clk);
        check(card_present == 0, "R1 not yet present", card_present, 0);
        repeat (4) @(negedge clk);
        check(card_present == 1 && card_reset == 0, "R1 present", card_present, 1);
        // R3 voltage sense
        card_vs1_n = 0; repeat (3) @(negedge clk);
        check(card_vcc3_en_n == 0, "R3 vcc enabled", card_vcc3_en_n, 0);
        // R6 word read of common memory
        cfg_strobe_min = 3;
        access(0, 0, 1, 11'h123, 16'h0);
        check(n_strobe == 3, "R6 strobe length", n_strobe, 3);
        check(got_rdata == 16'hA55A && !got_err, "R8 word read", got_rdata, 16'hA55A);
        check(!cap_ce1 && !cap_ce2 && !cap_a0 && cap_reg, "R4 word lanes", {cap_ce1, cap_ce2, cap_a0}, 0);
        // R4/R5 byte read, odd, attribute
        card_d_in = 16'h3C77;
        access(0, 1, 0, 11'h201, 16'h0);
        check(!cap_ce1 && cap_ce2 && cap_a0, "R4 byte odd lanes", {cap_ce1, cap_ce2, cap_a0}, 3'b011);
        check(cap_reg == 0, "R5 attribute select", cap_reg, 0);
        check(got_rdata == 16'h0077, "R4 byte read data", got_rdata, 16'h0077);
        // R8 byte write even
        access(1, 0, 0, 11'h044, 16'h00E1);
        check(cap_doe && cap_dout == 16'h00E1 && !cap_a0, "R8 write data", cap_dout, 16'h00E1);
        // R6 zero minimum behaves as one
        cfg_strobe_min = 0;
        access(1, 0, 1, 11'h046, 16'hBEEF);
        check(n_strobe == 1, "R6 zero min", n_strobe, 1);
        // R7 wait stretch
        cfg_strobe_min = 2; card_wait_n = 0;
        fork
            access(0, 0, 1, 11'h050, 16'h0);
            begin repeat (8) @(negedge clk); card_wait_n = 1; end
        join
        check(n_strobe > 2, "R7 stretched strobe", n_strobe, 3);
        // R10 ready / interrupt
        card_rdy = 0; repeat (3) @(negedge clk);
        check(card_irq == 1 && card_ready == 0, "R10 irq", card_irq, 1);
        card_rdy = 1;
        // R9 abort on removal in flight
        card_wait_n = 0;
        fork
            access(0, 0, 1, 11'h060, 16'h0);
            begin repeat (5) @(negedge clk); card_cd1_n = 1; end
        join
        check(got_err == 1, "R9 abort error", got_err, 1);
        @(negedge clk);
        check(card_oe_n && card_reset, "R9 strobe off after abort", card_oe_n, 1);
        card_wait_n = 1; card_vs1_n = 1;
        repeat (4) @(negedge clk);
        check(card_vcc3_en_n == 1, "R3 vcc off", card_vcc3_en_n, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule